// File: doc/BRIEF.md
# Trap Entry State Save Unit

When a processor with windowed registers takes a trap, it has to write a whole set of control registers in one step. This block computes that step and holds the result. On a request it takes the current trap level, global level, condition codes, ASI, processor-state, hypervisor-state and window pointer, together with PC, NPC, the trap type and the kind of entry. It then registers the next values of all of them.

The saved context is a 64-bit trap-state word, the saved PC and NPC, the trap type and the old hypervisor state. The live state is rewritten in one of three ways, depending on the destination: privileged entry, hyperprivileged entry, or entry into the reset/error (RED) state. Window traps also move the current window pointer. Vector address generation and the register storage are left to the surrounding core. The core latches the outputs when `done_o` pulses.

Top module: `trap_entry_save`

## Requirements
- R1: `done_o` is high in the cycle after every cycle with `req_i` high, and low after every cycle with `req_i` low. All other outputs keep their values when no request was sampled.
- R2: `tstate_o` holds the sampled global level in bits 42:40, the condition codes in 39:32, the ASI in 31:24, the processor state (13 bits) in 20:8 and the window pointer in 4:0. All other bits are zero.
- R3: `tl_o` is the sampled trap level plus one, modulo 2^TL_W. `tt_o` is the sampled trap type. `htstate_o` is the sampled hypervisor state.
- R4: `tpc_o`/`tnpc_o` equal PC/NPC. When processor-state bit 3 (address mask) is set, both are cut to their low 32 bits.
- R5: `gl_o` is min(GL+1, MAX_PGL) for privileged entry and min(GL+1, MAX_GL) for hyperprivileged or RED entry.
- R6: On privileged or hyperprivileged entry, processor-state bit 4 is set and bits 3 and 1 are cleared. The other bits pass through except as R7/R8 say.
- R7: On privileged entry (`to_hyp_i`=0, `red_i`=0), processor-state bit 2 is set and bit 9 takes the value of bit 8. The hypervisor state is unchanged.
- R8: On hyperprivileged entry (`to_hyp_i`=1, `red_i`=0), processor-state bit 9 is cleared. Hypervisor-state bit 5 is cleared, bit 2 is set, bit 10 is cleared, and the other bits are unchanged.
- R9: The window pointer moves by trap type. Type 0x24 adds 1. Types 0x80–0xBF add CANSAVE+2. Types 0xC0–0xFF subtract 1. All other types leave it unchanged. The result wraps modulo NWIN.
- R10: On RED entry (`red_i`=1, which has priority over `to_hyp_i`), the processor state keeps only bit 2 and also gets bit 4 set. The hypervisor state gets bits 5 and 2 set and bits 10 and 0 cleared.
- R11: During reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Trap request, sampled each clock |
| to_hyp_i | input | 1 | Destination is hyperprivileged |
| red_i | input | 1 | Entry into RED state |
| tt_i | input | 9 | Trap type |
| tl_i | input | TL_W | Current trap level |
| gl_i | input | GL_W | Current global level |
| ccr_i | input | 8 | Condition codes |
| asi_i | input | 8 | Current ASI |
| pstate_i | input | 13 | Processor state |
| hpstate_i | input | 11 | Hypervisor state |
| cwp_i | input | CWP_W | Current window pointer |
| cansave_i | input | CWP_W | Savable window count |
| pc_i | input | PC_W | Trapping PC |
| npc_i | input | PC_W | Trapping NPC |
| done_o | output | 1 | Next-state values valid |
| tl_o | output | TL_W | New trap level |
| tt_o | output | 9 | Recorded trap type |
| tstate_o | output | 64 | Packed trap-state word |
| tpc_o | output | PC_W | Saved PC |
| tnpc_o | output | PC_W | Saved NPC |
| htstate_o | output | 11 | Saved hypervisor state |
| gl_o | output | GL_W | New global level |
| pstate_o | output | 13 | New processor state |
| hpstate_o | output | 11 | New hypervisor state |
| cwp_o | output | CWP_W | New window pointer |

## Verification
All results pass through one register, so every output is due exactly one rising edge after the cycle that carries the request. The behavioural model in the bench is updated on the same rising edge from the inputs sampled there. Every output is compared with the model at the following falling edge, so results are never sampled while they are changing. The same per-cycle comparison covers idle cycles, which checks that the held values do not move between requests. It also covers back-to-back requests, where each result must replace the previous one after one cycle.

// File: rtl/trap_save_pkg.sv
package trap_save_pkg;
    localparam int PS_W  = 13;
    localparam int HPS_W = 11;
    localparam int TT_W  = 9;
    localparam int TSW_W = 64;

    // processor-state bit positions
    localparam int PS_IE   = 1;
    localparam int PS_PRIV = 2;
    localparam int PS_AM   = 3;
    localparam int PS_PEF  = 4;
    localparam int PS_TLE  = 8;
    localparam int PS_CLE  = 9;

    // hypervisor-state bit positions
    localparam int HP_TLZ  = 0;
    localparam int HP_PRIV = 2;
    localparam int HP_RED  = 5;
    localparam int HP_IBE  = 10;

    typedef enum logic [1:0] {
        ENTRY_PRIV = 2'd0,
        ENTRY_HYP  = 2'd1,
        ENTRY_RED  = 2'd2
    } entry_kind_e;
endpackage

// File: rtl/tse_tstate_pack.sv
module tse_tstate_pack
    import trap_save_pkg::*;
#(
    parameter int GL_W  = 2,
    parameter int CWP_W = 3
) (
    input  logic [GL_W-1:0]  gl,
    input  logic [7:0]       ccr,
    input  logic [7:0]       asi,
    input  logic [PS_W-1:0]  pstate,
    input  logic [CWP_W-1:0] cwp,
    output logic [TSW_W-1:0] word
);
    always_comb begin
        word        = '0;
        word[42:40] = 3'(gl);
        word[39:32] = ccr;
        word[31:24] = asi;
        word[20:8]  = pstate;
        word[4:0]   = 5'(cwp);
    end
endmodule

// File: rtl/tse_cwp_step.sv
module tse_cwp_step
    import trap_save_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int CWP_W = 3
) (
    input  logic [TT_W-1:0]  tt,
    input  logic [CWP_W-1:0] cwp,
    input  logic [CWP_W-1:0] cansave,
    output logic [CWP_W-1:0] cwp_next
);
    localparam int SW = CWP_W + 3;

    logic [SW-1:0] sum;

    always_comb begin
        if (tt == TT_W'(9'h024))
            sum = SW'(cwp) + SW'(1);
        else if (tt >= TT_W'(9'h080) && tt <= TT_W'(9'h0BF))
            sum = SW'(cwp) + SW'(cansave) + SW'(2);
        else if (tt >= TT_W'(9'h0C0) && tt <= TT_W'(9'h0FF))
            sum = SW'(cwp) + SW'(NWIN - 1);
        else
            sum = SW'(cwp);
        cwp_next = CWP_W'(sum % SW'(NWIN));
    end
endmodule

// File: rtl/tse_state_rewrite.sv
module tse_state_rewrite
    import trap_save_pkg::*;
#(
    parameter int GL_W    = 2,
    parameter int MAX_GL  = 3,
    parameter int MAX_PGL = 2
) (
    input  entry_kind_e      kind,
    input  logic [GL_W-1:0]  gl,
    input  logic [PS_W-1:0]  pstate,
    input  logic [HPS_W-1:0] hpstate,
    output logic [GL_W-1:0]  gl_next,
    output logic [PS_W-1:0]  pstate_next,
    output logic [HPS_W-1:0] hpstate_next
);
    logic [GL_W:0] gl_inc;
    logic [GL_W:0] gl_lim;

    always_comb begin
        gl_inc = {1'b0, gl} + 1'b1;
        gl_lim = (kind == ENTRY_PRIV) ? (GL_W+1)'(MAX_PGL) : (GL_W+1)'(MAX_GL);
        gl_next = (gl_inc > gl_lim) ? GL_W'(gl_lim) : GL_W'(gl_inc);

        pstate_next  = pstate;
        hpstate_next = hpstate;
        case (kind)
            ENTRY_RED: begin
                pstate_next          = '0;
                pstate_next[PS_PRIV] = pstate[PS_PRIV];
                pstate_next[PS_PEF]  = 1'b1;
                hpstate_next[HP_RED]  = 1'b1;
                hpstate_next[HP_PRIV] = 1'b1;
                hpstate_next[HP_IBE]  = 1'b0;
                hpstate_next[HP_TLZ]  = 1'b0;
            end
            ENTRY_HYP: begin
                pstate_next[PS_PEF] = 1'b1;
                pstate_next[PS_AM]  = 1'b0;
                pstate_next[PS_IE]  = 1'b0;
                pstate_next[PS_CLE] = 1'b0;
                hpstate_next[HP_RED]  = 1'b0;
                hpstate_next[HP_PRIV] = 1'b1;
                hpstate_next[HP_IBE]  = 1'b0;
            end
            default: begin
                pstate_next[PS_PEF]  = 1'b1;
                pstate_next[PS_AM]   = 1'b0;
                pstate_next[PS_IE]   = 1'b0;
                pstate_next[PS_PRIV] = 1'b1;
                pstate_next[PS_CLE]  = pstate[PS_TLE];
            end
        endcase
    end
endmodule

// File: rtl/trap_entry_save.sv
module trap_entry_save
    import trap_save_pkg::*;
#(
    parameter int PC_W    = 64,
    parameter int TL_W    = 3,
    parameter int NWIN    = 8,
    parameter int MAX_GL  = 3,
    parameter int MAX_PGL = 2,
    localparam int CWP_W  = $clog2(NWIN),
    localparam int GL_W   = $clog2(MAX_GL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             to_hyp_i,
    input  logic             red_i,
    input  logic [8:0]       tt_i,
    input  logic [TL_W-1:0]  tl_i,
    input  logic [GL_W-1:0]  gl_i,
    input  logic [7:0]       ccr_i,
    input  logic [7:0]       asi_i,
    input  logic [12:0]      pstate_i,
    input  logic [10:0]      hpstate_i,
    input  logic [CWP_W-1:0] cwp_i,
    input  logic [CWP_W-1:0] cansave_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [PC_W-1:0]  npc_i,
    output logic             done_o,
    output logic [TL_W-1:0]  tl_o,
    output logic [8:0]       tt_o,
    output logic [63:0]      tstate_o,
    output logic [PC_W-1:0]  tpc_o,
    output logic [PC_W-1:0]  tnpc_o,
    output logic [10:0]      htstate_o,
    output logic [GL_W-1:0]  gl_o,
    output logic [12:0]      pstate_o,
    output logic [10:0]      hpstate_o,
    output logic [CWP_W-1:0] cwp_o
);
    typedef struct packed {
        logic              done;
        logic [TL_W-1:0]   tl;
        logic [TT_W-1:0]   tt;
        logic [TSW_W-1:0]  tstate;
        logic [PC_W-1:0]   tpc;
        logic [PC_W-1:0]   tnpc;
        logic [HPS_W-1:0]  htstate;
        logic [GL_W-1:0]   gl;
        logic [PS_W-1:0]   pstate;
        logic [HPS_W-1:0]  hpstate;
        logic [CWP_W-1:0]  cwp;
    } save_regs_t;

    save_regs_t  st_d, st_q;
    entry_kind_e kind;
    logic [TSW_W-1:0] packed_word;
    logic [CWP_W-1:0] cwp_step;
    logic [GL_W-1:0]  gl_new;
    logic [PS_W-1:0]  ps_new;
    logic [HPS_W-1:0] hps_new;
    logic [PC_W-1:0]  pc_keep, npc_keep;

    assign kind = red_i ? ENTRY_RED : (to_hyp_i ? ENTRY_HYP : ENTRY_PRIV);

    tse_tstate_pack #(.GL_W(GL_W), .CWP_W(CWP_W)) u_pack (
        .gl(gl_i), .ccr(ccr_i), .asi(asi_i), .pstate(pstate_i), .cwp(cwp_i),
        .word(packed_word)
    );

    tse_cwp_step #(.NWIN(NWIN), .CWP_W(CWP_W)) u_cwp (
        .tt(tt_i), .cwp(cwp_i), .cansave(cansave_i), .cwp_next(cwp_step)
    );

    tse_state_rewrite #(.GL_W(GL_W), .MAX_GL(MAX_GL), .MAX_PGL(MAX_PGL)) u_rew (
        .kind(kind), .gl(gl_i), .pstate(pstate_i), .hpstate(hpstate_i),
        .gl_next(gl_new), .pstate_next(ps_new), .hpstate_next(hps_new)
    );

    // address-mask truncation of the saved program counters (PC_W > 32)
    always_comb begin
        pc_keep  = pc_i;
        npc_keep = npc_i;
        if (pstate_i[PS_AM]) begin
            pc_keep  = PC_W'(pc_i[31:0]);
            npc_keep = PC_W'(npc_i[31:0]);
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = req_i;
        if (req_i) begin
            st_d.tl      = tl_i + 1'b1;
            st_d.tt      = tt_i;
            st_d.tstate  = packed_word;
            st_d.tpc     = pc_keep;
            st_d.tnpc    = npc_keep;
            st_d.htstate = hpstate_i;
            st_d.gl      = gl_new;
            st_d.pstate  = ps_new;
            st_d.hpstate = hps_new;
            st_d.cwp     = cwp_step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o    = st_q.done;
    assign tl_o      = st_q.tl;
    assign tt_o      = st_q.tt;
    assign tstate_o  = st_q.tstate;
    assign tpc_o     = st_q.tpc;
    assign tnpc_o    = st_q.tnpc;
    assign htstate_o = st_q.htstate;
    assign gl_o      = st_q.gl;
    assign pstate_o  = st_q.pstate;
    assign hpstate_o = st_q.hpstate;
    assign cwp_o     = st_q.cwp;
endmodule

// File: rtl/trap_entry_save_chk.sv
module trap_entry_save_chk #(
    parameter int TL_W   = 3,
    parameter int GL_W   = 2,
    parameter int MAX_GL = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_i,
    input logic            to_hyp_i,
    input logic            red_i,
    input logic [TL_W-1:0] tl_i,
    input logic [12:0]     pstate_i,
    input logic [10:0]     hpstate_i,
    input logic            done_o,
    input logic [TL_W-1:0] tl_o,
    input logic [GL_W-1:0] gl_o,
    input logic [12:0]     pstate_o,
    input logic [10:0]     hpstate_o
);
    p_done_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> done_o);
    p_no_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !done_o);
    p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(tl_o) && $stable(pstate_o) && $stable(hpstate_o));
    p_tl_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> tl_o == TL_W'($past(tl_i) + 1'b1));
    p_gl_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> int'(gl_o) <= MAX_GL);
    p_pef_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> pstate_o[4]);
    p_priv_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !red_i && !to_hyp_i |=>
            pstate_o[2] && pstate_o[9] == $past(pstate_i[8]) && hpstate_o == $past(hpstate_i));
    p_hyp_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !red_i && to_hyp_i |=> hpstate_o[2] && !hpstate_o[5] && !hpstate_o[10] && !pstate_o[9]);
    p_red_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && red_i |=> hpstate_o[5] && hpstate_o[2] && !hpstate_o[0] && pstate_o[12:5] == 8'd0);
endmodule

bind trap_entry_save trap_entry_save_chk #(.TL_W(TL_W), .GL_W(GL_W), .MAX_GL(MAX_GL)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .to_hyp_i(to_hyp_i), .red_i(red_i),
    .tl_i(tl_i), .pstate_i(pstate_i), .hpstate_i(hpstate_i), .done_o(done_o),
    .tl_o(tl_o), .gl_o(gl_o), .pstate_o(pstate_o), .hpstate_o(hpstate_o)
);

// File: tb/sim_trap_entry_save.sv
`timescale 1ns/100ps
module sim_trap_entry_save;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, to_hyp = 1'b0, red = 1'b0;
    logic [8:0]  tt = '0;
    logic [2:0]  tl = '0;
    logic [1:0]  gl = '0;
    logic [7:0]  ccr = '0, asi = '0;
    logic [12:0] ps = '0;
    logic [10:0] hps = '0;
    logic [2:0]  cwp = '0, cansave = '0;
    logic [63:0] pc = '0, npc = '0;

    logic        done_o;
    logic [2:0]  tl_o, cwp_o;
    logic [8:0]  tt_o;
    logic [63:0] tstate_o, tpc_o, tnpc_o;
    logic [10:0] htstate_o, hpstate_o;
    logic [1:0]  gl_o;
    logic [12:0] pstate_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    trap_entry_save u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .to_hyp_i(to_hyp), .red_i(red),
        .tt_i(tt), .tl_i(tl), .gl_i(gl), .ccr_i(ccr), .asi_i(asi),
        .pstate_i(ps), .hpstate_i(hps), .cwp_i(cwp), .cansave_i(cansave),
        .pc_i(pc), .npc_i(npc), .done_o(done_o), .tl_o(tl_o), .tt_o(tt_o),
        .tstate_o(tstate_o), .tpc_o(tpc_o), .tnpc_o(tnpc_o), .htstate_o(htstate_o),
        .gl_o(gl_o), .pstate_o(pstate_o), .hpstate_o(hpstate_o), .cwp_o(cwp_o)
    );

    // behavioural reference model, updated on each rising edge
    logic [63:0] m_done, m_tl, m_tt, m_tst, m_tpc, m_tnpc, m_hts, m_gl, m_ps, m_hps, m_cwp;
    string kind_tag = "R7";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_done, m_tl, m_tt, m_tst, m_tpc, m_tnpc} = '0;
            {m_hts, m_gl, m_ps, m_hps, m_cwp} = '0;
        end else begin
            m_done = {63'd0, req};
            if (req) begin
                int lim, g, w;
                m_tl  = (tl + 1) % 8;
                m_tt  = tt;
                m_tst = (64'(gl) << 40) | (64'(ccr) << 32) | (64'(asi) << 24)
                      | (64'(ps) << 8) | 64'(cwp);
                m_tpc  = ps[3] ? (pc & 64'hFFFF_FFFF) : pc;
                m_tnpc = ps[3] ? (npc & 64'hFFFF_FFFF) : npc;
                m_hts  = hps;
                lim = (red || to_hyp) ? 3 : 2;
                g = gl + 1;
                m_gl = (g > lim) ? lim : g;
                if (red) begin
                    kind_tag = "R10";
                    m_ps  = (ps & 13'h004) | 13'h010;
                    m_hps = (hps | 11'h024) & ~11'h401;
                end else if (to_hyp) begin
                    kind_tag = "R8";
                    m_ps  = (ps | 13'h010) & ~13'h20A;
                    m_hps = (hps & ~11'h420) | 11'h004;
                end else begin
                    kind_tag = "R7";
                    m_ps  = ((ps | 13'h014) & ~13'h20A) | (ps[8] ? 13'h200 : 13'h000);
                    m_hps = hps;
                end
                w = cwp;
                if (tt == 9'h024) w = w + 1;
                else if (tt >= 9'h080 && tt <= 9'h0BF) w = w + cansave + 2;
                else if (tt >= 9'h0C0 && tt <= 9'h0FF) w = w + 7;
                m_cwp = w % 8;
            end
        end
    end

    task automatic chk(input string tag, input string fld, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, fld, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R11", "reset outputs", {done_o, tl_o, gl_o, cwp_o, pstate_o, hpstate_o} | tstate_o | tpc_o, '0);
        end else begin
            chk("R1", "done", 64'(done_o), m_done);
            chk("R3", "tl", 64'(tl_o), m_tl);
            chk("R3", "tt", 64'(tt_o), m_tt);
            chk("R3", "htstate", 64'(htstate_o), m_hts);
            chk("R2", "tstate", tstate_o, m_tst);
            chk("R4", "tpc", tpc_o, m_tpc);
            chk("R4", "tnpc", tnpc_o, m_tnpc);
            chk("R5", "gl", 64'(gl_o), m_gl);
            chk("R6", {kind_tag, " pstate"}, 64'(pstate_o), m_ps);
            chk(kind_tag, "hpstate", 64'(hpstate_o), m_hps);
            chk("R9", "cwp", 64'(cwp_o), m_cwp);
        end
    end

    task automatic fire(input logic h, input logic r, input logic [8:0] t,
                        input logic [2:0] w, input logic [2:0] cs, input logic [1:0] g,
                        input logic [12:0] p);
        @(negedge clk);
        req = 1'b1; to_hyp = h; red = r; tt = t; cwp = w; cansave = cs; gl = g; ps = p;
        tl = 3'($urandom); ccr = 8'($urandom); asi = 8'($urandom);
        hps = 11'($urandom); pc = {$urandom, $urandom}; npc = {$urandom, $urandom};
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R9 window moves and wrap
        fire(0, 0, 9'h024, 3'd7, 3'd0, 2'd0, 13'h0000);
        fire(0, 0, 9'h080, 3'd6, 3'd7, 2'd1, 13'h0100);
        fire(0, 0, 9'h0BF, 3'd1, 3'd2, 2'd2, 13'h000A);
        fire(1, 0, 9'h0C0, 3'd0, 3'd3, 2'd3, 13'h1FFF);
        fire(1, 0, 9'h0FF, 3'd5, 3'd3, 2'd2, 13'h0208);
        fire(0, 0, 9'h100, 3'd4, 3'd5, 2'd3, 13'h0008);
        fire(0, 0, 9'h07F, 3'd4, 3'd5, 2'd0, 13'h0000);
        // R10 RED entry, with and without hyp flag
        fire(0, 1, 9'h005, 3'd2, 3'd1, 2'd3, 13'h1FFF);
        fire(1, 1, 9'h001, 3'd2, 3'd1, 2'd1, 13'h1FFB);
        repeat (4) @(negedge clk);
        // back-to-back requests then random traffic, R1 hold on idle cycles
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            req = ($urandom % 3) != 0; to_hyp = 1'($urandom); red = ($urandom % 5) == 0;
            tt = 9'($urandom); tl = 3'($urandom); gl = 2'($urandom);
            ccr = 8'($urandom); asi = 8'($urandom); ps = 13'($urandom);
            hps = 11'($urandom); cwp = 3'($urandom); cansave = 3'($urandom);
            pc = {$urandom, $urandom}; npc = {$urandom, $urandom};
        end
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule